// File: doc/BRIEF.md
# Saturating Viterbi Add-Compare-Select Step

This block carries out a single add-compare-select step for one trellis state of a rate-1/3 hard-decision Viterbi decoder. Each state has two incoming edges. For each edge the block takes the path metric of the predecessor state and the 3-bit code word expected on that edge. It also takes the 3-bit code word received for the current symbol period. The edge weight is the Hamming distance between the received and expected words. The block adds that weight to the predecessor metric and keeps the smaller of the two candidate sums as the new state metric. A one-bit survivor decision records which predecessor won; an external traceback store consumes it.

Metrics are unsigned 16-bit values, and every addition saturates at 65535 rather than wrapping. A predictor works out, before any adder runs, whether each candidate sum would pass the top of the range. If either candidate would saturate, the comparator is not used for that operation, and the adder of the saturating edge has its operands held at zero. When only one candidate saturates, the other one is selected directly. When both saturate, the result is the ceiling value. The `gate_active` output shows whether the comparator was enabled, so the gating can be observed from outside.

The unit is fully registered. It accepts one operation per cycle and presents the result one cycle after the operation is offered.

Top module: `acs_sat_unit`

## Requirements
- R1: Each edge weight is the number of bit positions in which the 3-bit received word `rx_code` differs from that edge's expected word (`exp0_code` for edge 0, `exp1_code` for edge 1), giving a value from 0 to 3.
- R2: When neither candidate saturates, `out_metric` is the smaller of `pm0_in`+weight0 and `pm1_in`+weight1. `out_dec` is 1 exactly when the edge-1 sum is strictly smaller.
- R3: When the two unsaturated candidate sums are equal, edge 0 is chosen and `out_dec` is 0.
- R4: A candidate sum overflows only if it is strictly greater than 65535. A sum of exactly 65535 is an ordinary value that goes through the comparison, and no output ever shows a wrapped sum.
- R5: When exactly one candidate overflows, the other candidate's sum is output without comparison. `out_dec` gives the index of the non-overflowing edge, and `gate_active` is 0.
- R6: When both candidates overflow, `out_metric` is 65535, `out_dec` is 0 and `gate_active` is 0.
- R7: `gate_active` is 1 for an operation exactly when neither candidate overflows.
- R8: `out_valid` follows `in_valid` with one cycle of latency, and a new operation is accepted every cycle. In a cycle after `in_valid` was 0, `out_metric`, `out_dec` and `gate_active` keep their previous values.
- R9: While `rst` is high, the next clock edge sets `out_valid`, `out_metric`, `out_dec` and `gate_active` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered this cycle |
| pm0_in | input | 16 | Path metric of predecessor on edge 0 |
| pm1_in | input | 16 | Path metric of predecessor on edge 1 |
| rx_code | input | 3 | Hard-decision received code word |
| exp0_code | input | 3 | Code word expected on edge 0 |
| exp1_code | input | 3 | Code word expected on edge 1 |
| out_valid | output | 1 | Result registers hold a new operation |
| out_metric | output | 16 | New state metric |
| out_dec | output | 1 | Survivor decision: 0 = edge 0, 1 = edge 1 |
| gate_active | output | 1 | Comparator enabled for this operation |

## Verification
On every cycle, the assertions check the link between the overflow predictions and the registered result. They cover the both-saturated result, the direct choice of a single survivor, the tie rule, the minimum property of unsaturated selections, the valid latency and output hold, and the reset values. Only the bench's vectors can show that the Hamming weights are right for particular code words. The vectors also show that sums landing exactly on 65535 are not treated as overflow, and that the absolute metric values match independent hand-worked results.

// File: rtl/acs_sat_pkg.sv
package acs_sat_pkg;

    localparam int unsigned PM_W   = 16;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned WT_W   = $clog2(CODE_W + 1);
    localparam int unsigned N_EDGE = 2;

    localparam logic [PM_W-1:0] PM_CEIL = {PM_W{1'b1}};

    typedef logic [PM_W-1:0]   metric_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [WT_W-1:0]   weight_t;

    // How the select stage resolves one operation.
    typedef enum logic [1:0] {
        SEL_COMPARE = 2'd0,
        SEL_ONLY_E0 = 2'd1,
        SEL_ONLY_E1 = 2'd2,
        SEL_CEILING = 2'd3
    } sel_mode_t;

    // Per-edge datapath bundle.
    typedef struct packed {
        weight_t weight;
        logic    ovf;
        metric_t sum;
    } edge_res_t;

    // Result of one add-compare-select operation.
    typedef struct packed {
        metric_t metric;
        logic    dec;
        logic    gate;
    } acs_res_t;

    // Hamming distance between two code words.
    function automatic weight_t code_dist(input code_t a, input code_t b);
        weight_t n;
        n = '0;
        for (int i = 0; i < CODE_W; i++) begin
            n = n + weight_t'(a[i] ^ b[i]);
        end
        return n;
    endfunction

    // True when pm + w would exceed the metric range; no adder needed.
    function automatic logic add_would_ovf(input metric_t pm, input weight_t w);
        metric_t headroom;
        headroom = PM_CEIL - pm;
        return headroom < metric_t'(w);
    endfunction

endpackage

// File: rtl/acs_edge.sv
module acs_edge
    import acs_sat_pkg::*;
(
    input  metric_t   pm,
    input  code_t     rx,
    input  code_t     expect_code,
    output edge_res_t res
);
    weight_t w;
    logic    ovf;
    metric_t pm_iso;
    weight_t w_iso;

    always_comb begin
        w      = code_dist(rx, expect_code);
        ovf    = add_would_ovf(pm, w);
        // Operand isolation: a saturating edge keeps its adder inputs quiet.
        pm_iso = ovf ? '0 : pm;
        w_iso  = ovf ? '0 : w;
        res.weight = w;
        res.ovf    = ovf;
        res.sum    = ovf ? PM_CEIL : (pm_iso + metric_t'(w_iso));
    end
endmodule

// File: rtl/acs_select.sv
module acs_select
    import acs_sat_pkg::*;
(
    input  edge_res_t e0,
    input  edge_res_t e1,
    output acs_res_t  res
);
    sel_mode_t mode;
    logic      cmp_en;
    metric_t   cmp_a;
    metric_t   cmp_b;
    logic      e1_less;

    always_comb begin
        unique case ({e1.ovf, e0.ovf})
            2'b00:   mode = SEL_COMPARE;
            2'b10:   mode = SEL_ONLY_E0;
            2'b01:   mode = SEL_ONLY_E1;
            default: mode = SEL_CEILING;
        endcase
        cmp_en  = (mode == SEL_COMPARE);
        // Comparator inputs held at zero when not needed.
        cmp_a   = cmp_en ? e0.sum : '0;
        cmp_b   = cmp_en ? e1.sum : '0;
        e1_less = cmp_b < cmp_a;

        res.gate = cmp_en;
        unique case (mode)
            SEL_COMPARE: begin
                res.metric = e1_less ? e1.sum : e0.sum;
                res.dec    = e1_less;
            end
            SEL_ONLY_E0: begin
                res.metric = e0.sum;
                res.dec    = 1'b0;
            end
            SEL_ONLY_E1: begin
                res.metric = e1.sum;
                res.dec    = 1'b1;
            end
            default: begin
                res.metric = PM_CEIL;
                res.dec    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acs_sat_unit.sv
module acs_sat_unit
    import acs_sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PM_W-1:0]   pm0_in,
    input  logic [PM_W-1:0]   pm1_in,
    input  logic [CODE_W-1:0] rx_code,
    input  logic [CODE_W-1:0] exp0_code,
    input  logic [CODE_W-1:0] exp1_code,
    output logic              out_valid,
    output logic [PM_W-1:0]   out_metric,
    output logic              out_dec,
    output logic              gate_active
);
    metric_t   pm_arr  [N_EDGE];
    code_t     exp_arr [N_EDGE];
    edge_res_t edge_res [N_EDGE];
    acs_res_t  sel_res;
    acs_res_t  res_q;

    assign pm_arr[0]  = pm0_in;
    assign pm_arr[1]  = pm1_in;
    assign exp_arr[0] = exp0_code;
    assign exp_arr[1] = exp1_code;

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        acs_edge u_edge (
            .pm          (pm_arr[g]),
            .rx          (rx_code),
            .expect_code (exp_arr[g]),
            .res         (edge_res[g])
        );
    end

    acs_select u_select (
        .e0  (edge_res[0]),
        .e1  (edge_res[1]),
        .res (sel_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= sel_res;
            end
        end
    end

    assign out_metric  = res_q.metric;
    assign out_dec     = res_q.dec;
    assign gate_active = res_q.gate;

    // R6: both candidates saturating yields the ceiling, edge 0, no compare
    p_both_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && edge_res[0].ovf && edge_res[1].ovf)
        |=> (out_metric == PM_CEIL && !out_dec && !gate_active));

    // R5: a lone saturating edge picks the other edge directly
    p_lone_e1_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && edge_res[0].ovf && !edge_res[1].ovf)
        |=> (out_dec && !gate_active && out_metric == $past(edge_res[1].sum)));

    p_lone_e0_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !edge_res[0].ovf && edge_res[1].ovf)
        |=> (!out_dec && !gate_active && out_metric == $past(edge_res[0].sum)));

    // R2 / R7: unsaturated operations run the compare and keep the minimum
    p_min_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !edge_res[0].ovf && !edge_res[1].ovf)
        |=> (gate_active && out_metric <= $past(edge_res[0].sum)
             && out_metric <= $past(edge_res[1].sum)));

    // R3: equal sums favour edge 0
    p_tie_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !edge_res[0].ovf && !edge_res[1].ovf
         && edge_res[0].sum == edge_res[1].sum)
        |=> !out_dec);

    // R8: one-cycle valid latency and hold while idle
    p_lat_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst))
        |=> ($stable(out_metric) && $stable(out_dec) && $stable(gate_active)));

    // R9: reset clears the result registers
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_metric == '0 && !out_dec && !gate_active));

endmodule

// File: tb/acs_sat_unit_bench.sv
module acs_sat_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;

    // {pm0, pm1, rx, exp0, exp1, exp_metric, exp_dec, exp_gate}
    typedef struct packed {
        logic [15:0] pm0;
        logic [15:0] pm1;
        logic [2:0]  rx;
        logic [2:0]  e0;
        logic [2:0]  e1;
        logic [15:0] metric;
        logic        dec;
        logic        gate;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        // R1/R2: weights 0 and 3, edge 0 wins
        '{16'd10,    16'd20,    3'b000, 3'b000, 3'b111, 16'd10,    1'b0, 1'b1},
        // R1/R2: weights 3 and 1, edge 1 wins
        '{16'd30,    16'd20,    3'b101, 3'b010, 3'b100, 16'd21,    1'b1, 1'b1},
        // R3: tie at 6
        '{16'd5,     16'd6,     3'b110, 3'b100, 3'b110, 16'd6,     1'b0, 1'b1},
        // R5: edge 0 saturates
        '{16'd65534, 16'd100,   3'b111, 3'b000, 3'b111, 16'd100,   1'b1, 1'b0},
        // R5: edge 1 saturates
        '{16'd65000, 16'd65535, 3'b000, 3'b000, 3'b001, 16'd65000, 1'b0, 1'b0},
        // R6: both saturate
        '{16'd65535, 16'd65533, 3'b000, 3'b011, 3'b111, 16'd65535, 1'b0, 1'b0},
        // R4: both land exactly on the ceiling, no overflow, tie
        '{16'd65533, 16'd65535, 3'b000, 3'b011, 3'b000, 16'd65535, 1'b0, 1'b1},
        // R4: ceiling vs one below, edge 1 wins by compare
        '{16'd65535, 16'd65533, 3'b000, 3'b000, 3'b100, 16'd65534, 1'b1, 1'b1},
        // R2: all-zero metrics
        '{16'd0,     16'd0,     3'b010, 3'b010, 3'b000, 16'd0,     1'b0, 1'b1},
        // R1/R2: weights 1 and 3
        '{16'd7,     16'd0,     3'b111, 3'b110, 3'b000, 16'd3,     1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] pm0_in, pm1_in;
    logic [2:0]  rx_code, exp0_code, exp1_code;
    logic        out_valid;
    logic [15:0] out_metric;
    logic        out_dec;
    logic        gate_active;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acs_sat_unit u_acs_sat_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .pm0_in      (pm0_in),
        .pm1_in      (pm1_in),
        .rx_code     (rx_code),
        .exp0_code   (exp0_code),
        .exp1_code   (exp1_code),
        .out_valid   (out_valid),
        .out_metric  (out_metric),
        .out_dec     (out_dec),
        .gate_active (gate_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input vec_t t);
        in_valid  = v;
        pm0_in    = t.pm0;
        pm1_in    = t.pm1;
        rx_code   = t.rx;
        exp0_code = t.e0;
        exp1_code = t.e1;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b1, VECS[1]);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out_valid", out_valid, 0);
        chk("R9 out_metric", out_metric, 0);
        chk("R9 out_dec", out_dec, 0);
        chk("R9 gate_active", gate_active, 0);
        rst = 1'b0;
        drive(1'b0, VECS[0]);
        @(negedge clk);

        // Table walk, one operation per cycle, checked one cycle later
        for (int i = 0; i < N_VEC; i++) begin
            drive(1'b1, VECS[i]);
            @(negedge clk);
            chk($sformatf("R8 valid vec%0d", i), out_valid, 1);
            chk($sformatf("R2 metric vec%0d", i), out_metric, VECS[i].metric);
            chk($sformatf("R3 dec vec%0d", i), out_dec, VECS[i].dec);
            chk($sformatf("R7 gate vec%0d", i), gate_active, VECS[i].gate);
        end

        // R8: idle cycle with new data keeps the previous result
        drive(1'b0, VECS[3]);
        @(negedge clk);
        chk("R8 idle valid", out_valid, 0);
        chk("R8 idle metric held", out_metric, VECS[N_VEC-1].metric);
        chk("R8 idle dec held", out_dec, VECS[N_VEC-1].dec);
        chk("R8 idle gate held", gate_active, VECS[N_VEC-1].gate);

        // R6: both saturate after an idle cycle
        drive(1'b1, VECS[5]);
        @(negedge clk);
        chk("R6 ceiling metric", out_metric, 65535);
        chk("R6 dec", out_dec, 0);
        chk("R6 gate off", gate_active, 0);

        // R5: edge 0 overflows by one
        drive(1'b1, '{16'd65535, 16'd40, 3'b001, 3'b000, 3'b001,
                      16'd0, 1'b0, 1'b0});
        @(negedge clk);
        chk("R5 lone survivor metric", out_metric, 40);
        chk("R5 lone survivor dec", out_dec, 1);
        chk("R5 gate off", gate_active, 0);

        // R9: reset mid-stream clears the outputs
        drive(1'b1, VECS[1]);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset valid", out_valid, 0);
        chk("R9 mid reset metric", out_metric, 0);
        rst = 1'b0;
        drive(1'b0, VECS[0]);
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule